// File: doc/BRIEF.md
# Line-Hold Interrupt Detector

This block watches a port's line inputs and raises an interrupt once a chosen line condition has held without a break for long enough. A mode input selects which condition is watched. With the mode low it watches for a single-ended zero, where both differential data lines are low. With the mode high it watches for the serial-peripheral data line being held low. Only one source can be active at a time.

The duration is measured on a coarse timebase. A periodic tick input, nominally every 128 µs, is counted while the condition holds. The interrupt fires on the second tick rising edge. Because the first edge can arrive anywhere within a tick period, the condition is qualified after 128 to 256 µs. Any break in the condition clears the count. So does any change of the mode input.

The block has two outputs. The first is a one-cycle interrupt pulse, issued once per continuous assertion of the condition. The second is a status level that stays high from that pulse until the condition goes away. Each line input passes through a two-flop synchronizer before it is evaluated.

Top module: `busHoldDetector`

## Requirements
- R1: After reset, `irqPulse` and `holdStatus` are both 0.
- R2: With `modeSel` = 0, the condition is `dPlusIn` = 0 and `dMinusIn` = 0 together. Only one of them low is no condition. `sDataIn` has no effect in this mode.
- R3: With `modeSel` = 1, the condition is `sDataIn` = 0. The D+ and D- lines have no effect in this mode.
- R4: The first `tickIn` rising edge seen during a continuous condition gives no interrupt. The second one gives `irqPulse` within 3 clock cycles.
- R5: `irqPulse` is high for exactly one clock cycle. It fires at most once per continuous condition, however many more tick edges follow.
- R6: `holdStatus` rises together with `irqPulse`. It stays high while the condition holds, and falls within 4 cycles after the condition ends.
- R7: A break in the condition of a few clock cycles clears the tick count. After the break, two fresh tick edges are needed to fire.
- R8: A change of `modeSel` clears the tick count and drops `holdStatus`.
- R9: Only rising edges of `tickIn` are counted. A tick held high for many cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 1 | 0 watches for a single-ended zero, 1 watches for the data line held low |
| dPlusIn | input | 1 | D+ line, asynchronous |
| dMinusIn | input | 1 | D- line, asynchronous |
| sDataIn | input | 1 | Serial-peripheral data line, asynchronous |
| tickIn | input | 1 | Coarse timebase tick, synchronous to clk |
| irqPulse | output | 1 | One-cycle interrupt pulse |
| holdStatus | output | 1 | High from the interrupt until the condition ends |

## Verification
The basic check holds each mode's true condition across several ticks. This separates the silent first edge from the firing second edge, and shows that the interrupt does not re-fire on later edges. Partial conditions are applied next: only D+ low in the default mode, and a full single-ended zero with the data line high in the other mode. These show that each mode decodes only its own lines. A short break in the condition, a mode flip during a count and a tick held high for many cycles are each used to tell a cleared count apart from a carried-over one, and edge counting apart from level counting.

// File: rtl/busHoldPkg.sv
`timescale 1ns/1ps
package busHoldPkg;
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } holdStrobe_t;

  typedef enum logic {
    ST_WAIT  = 1'b0,
    ST_FIRED = 1'b1
  } holdState_t;
endpackage

// File: rtl/busHoldDatapath.sv
`timescale 1ns/1ps
module busHoldDatapath
  import busHoldPkg::*;
#(
  parameter int TICKS_NEEDED = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeSel,
  input  logic        dPlusIn,
  input  logic        dMinusIn,
  input  logic        sDataIn,
  input  logic        tickIn,
  input  holdStrobe_t strb,
  output logic        condNow,
  output logic        tickRise,
  output logic        modeChg,
  output logic        lastTick
);
  localparam int CNT_W = (TICKS_NEEDED < 2) ? 1 : $clog2(TICKS_NEEDED);
  localparam int LINES = 3;

  logic [SYNC_STAGES-1:0][LINES-1:0] syncPipe;
  logic [LINES-1:0] lineVec;
  logic [LINES-1:0] lineSync;
  logic             tickQ;
  logic             modeQ;
  logic [CNT_W-1:0] tickCnt;

  assign lineVec = {sDataIn, dMinusIn, dPlusIn};

  // synchronizer chain, idle lines reset high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '1;
    end else begin
      syncPipe[0] <= lineVec;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        syncPipe[s] <= syncPipe[s-1];
      end
    end
  end

  assign lineSync = syncPipe[SYNC_STAGES-1];

  always_comb begin
    if (modeSel) condNow = ~lineSync[2];
    else         condNow = ~lineSync[0] & ~lineSync[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ <= 1'b0;
      modeQ <= 1'b0;
    end else begin
      tickQ <= tickIn;
      modeQ <= modeSel;
    end
  end

  assign tickRise = tickIn & ~tickQ;
  assign modeChg  = modeSel ^ modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.clrCnt) begin
      tickCnt <= '0;
    end else if (strb.incCnt) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign lastTick = (tickCnt == CNT_W'(TICKS_NEEDED - 1));
endmodule

// File: rtl/busHoldControl.sv
`timescale 1ns/1ps
module busHoldControl
  import busHoldPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        condNow,
  input  logic        tickRise,
  input  logic        modeChg,
  input  logic        lastTick,
  output holdStrobe_t strb,
  output logic        irqPulse,
  output logic        holdStatus
);
  holdState_t state, nextState;
  logic       fireNow;

  always_comb begin
    strb      = '0;
    fireNow   = 1'b0;
    nextState = state;
    if (!condNow || modeChg) begin
      strb.clrCnt = 1'b1;
      nextState   = ST_WAIT;
    end else if (state == ST_WAIT && tickRise) begin
      if (lastTick) begin
        fireNow     = 1'b1;
        strb.clrCnt = 1'b1;
        nextState   = ST_FIRED;
      end else begin
        strb.incCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      irqPulse <= 1'b0;
    end else begin
      state    <= nextState;
      irqPulse <= fireNow;
    end
  end

  assign holdStatus = (state == ST_FIRED);
endmodule

// File: rtl/busHoldDetector.sv
`timescale 1ns/1ps
module busHoldDetector
  import busHoldPkg::*;
#(
  parameter int TICKS_NEEDED = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic modeSel,
  input  logic dPlusIn,
  input  logic dMinusIn,
  input  logic sDataIn,
  input  logic tickIn,
  output logic irqPulse,
  output logic holdStatus
);
  holdStrobe_t strb;
  logic condNow, tickRise, modeChg, lastTick;

  busHoldDatapath #(
    .TICKS_NEEDED(TICKS_NEEDED),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .dPlusIn (dPlusIn),
    .dMinusIn(dMinusIn),
    .sDataIn (sDataIn),
    .tickIn  (tickIn),
    .strb    (strb),
    .condNow (condNow),
    .tickRise(tickRise),
    .modeChg (modeChg),
    .lastTick(lastTick)
  );

  busHoldControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .condNow   (condNow),
    .tickRise  (tickRise),
    .modeChg   (modeChg),
    .lastTick  (lastTick),
    .strb      (strb),
    .irqPulse  (irqPulse),
    .holdStatus(holdStatus)
  );
endmodule

// File: rtl/busHoldChecker.sv
`timescale 1ns/1ps
module busHoldChecker (
  input logic clk,
  input logic rstN,
  input logic modeSel,
  input logic tickIn,
  input logic irqPulse,
  input logic holdStatus
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R5
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rstN)
    (holdStatus && $past(holdStatus)) |-> !irqPulse); // R5
  AST_IRQ_WITH_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> holdStatus); // R6
  AST_STATUS_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdStatus) |-> irqPulse); // R6
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) != $past(modeSel, 2)) |-> !holdStatus); // R8
  AST_IRQ_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(tickIn) && !$past(tickIn, 2))); // R9
endmodule

bind busHoldDetector busHoldChecker u_check (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .tickIn    (tickIn),
  .irqPulse  (irqPulse),
  .holdStatus(holdStatus)
);

// File: tb/busHoldDetector_tb.sv
`timescale 1ns/1ps
module busHoldDetector_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0;
  logic dPlusIn = 1'b1;
  logic dMinusIn = 1'b1;
  logic sDataIn = 1'b1;
  logic tickIn = 1'b0;
  logic irqPulse, holdStatus;
  int   checks = 0;
  int   errors = 0;
  int   irqCnt = 0;
  int   base;

  always #4 clk = ~clk;

  busHoldDetector u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .dPlusIn(dPlusIn),
    .dMinusIn(dMinusIn), .sDataIn(sDataIn), .tickIn(tickIn),
    .irqPulse(irqPulse), .holdStatus(holdStatus)
  );

  // one count per high cycle of the pulse
  always @(posedge clk) if (irqPulse === 1'b1) irqCnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) tickIn = 1'b1;
    @(negedge clk) tickIn = 1'b0;
    waitCyc(4);
  endtask

  task automatic setLines(input logic dp, input logic dm, input logic sd);
    @(negedge clk);
    dPlusIn = dp; dMinusIn = dm; sDataIn = sd;
    waitCyc(4);
  endtask

  task automatic idleAll();
    setLines(1'b1, 1'b1, 1'b1);
    waitCyc(4);
  endtask

  task automatic t_reset();
    check("R1 irq after reset", int'(irqPulse), 0);
    check("R1 status after reset", int'(holdStatus), 0);
  endtask

  task automatic t_usbBasic();
    modeSel = 1'b0;
    setLines(1'b0, 1'b0, 1'b1);
    base = irqCnt;
    tick();
    check("R4 no irq on first edge", irqCnt - base, 0);
    tick();
    check("R4 irq on second edge", irqCnt - base, 1);
    check("R6 status high after irq", int'(holdStatus), 1);
    tick(); tick();
    check("R5 single pulse per hold", irqCnt - base, 1);
    check("R6 status holds", int'(holdStatus), 1);
    setLines(1'b1, 1'b1, 1'b1);
    check("R6 status falls after release", int'(holdStatus), 0);
    waitCyc(4);
  endtask

  task automatic t_usbPartial();
    modeSel = 1'b0;
    setLines(1'b0, 1'b1, 1'b0);
    base = irqCnt;
    tick(); tick(); tick();
    check("R2 one D line low plus data low", irqCnt - base, 0);
    check("R2 status stays low", int'(holdStatus), 0);
    idleAll();
  endtask

  task automatic t_ps2Basic();
    @(negedge clk) modeSel = 1'b1;
    waitCyc(4);
    setLines(1'b1, 1'b1, 1'b0);
    base = irqCnt;
    tick();
    check("R3 no irq on first edge", irqCnt - base, 0);
    tick();
    check("R3 data low fires", irqCnt - base, 1);
    idleAll();
  endtask

  task automatic t_ps2IgnoreSe0();
    setLines(1'b0, 1'b0, 1'b1);
    base = irqCnt;
    tick(); tick(); tick();
    check("R3 SE0 ignored in data mode", irqCnt - base, 0);
    idleAll();
    @(negedge clk) modeSel = 1'b0;
    waitCyc(4);
  endtask

  task automatic t_gap();
    setLines(1'b0, 1'b0, 1'b1);
    base = irqCnt;
    tick();
    @(negedge clk) dPlusIn = 1'b1;
    waitCyc(3);
    dPlusIn = 1'b0;
    waitCyc(4);
    tick();
    check("R7 count cleared by gap", irqCnt - base, 0);
    tick();
    check("R7 fires after two fresh edges", irqCnt - base, 1);
    idleAll();
  endtask

  task automatic t_modeChange();
    setLines(1'b0, 1'b0, 1'b0);
    base = irqCnt;
    tick();
    @(negedge clk) modeSel = 1'b1;
    waitCyc(4);
    tick();
    check("R8 count cleared by mode change", irqCnt - base, 0);
    tick();
    check("R8 fires in new mode", irqCnt - base, 1);
    check("R8 status set before flip", int'(holdStatus), 1);
    @(negedge clk) modeSel = 1'b0;
    waitCyc(4);
    check("R8 status dropped by mode change", int'(holdStatus), 0);
    tick(); tick();
    check("R8 refires after mode change", irqCnt - base, 2);
    idleAll();
  endtask

  task automatic t_longTick();
    setLines(1'b0, 1'b0, 1'b1);
    base = irqCnt;
    @(negedge clk) tickIn = 1'b1;
    waitCyc(10);
    tickIn = 1'b0;
    waitCyc(4);
    check("R9 held tick counts once", irqCnt - base, 0);
    tick();
    check("R9 next edge fires", irqCnt - base, 1);
    idleAll();
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);
    t_reset();
    t_usbBasic();
    t_usbPartial();
    t_ps2Basic();
    t_ps2IgnoreSe0();
    t_gap();
    t_modeChange();
    t_longTick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule